// File: doc/BRIEF.md
# Non-Pipelined Dispatch Throttle

This block sits between a two-pipe instruction issue stage (primary and secondary) and the execution pipes. In normal operation it passes issue requests straight through as grants. When a debug controller selects a serialized execution mode, the block lets one dispatch through and then stalls all issue. The stall lasts until the machine is fully quiescent: the issued instructions have completed, all memory cycles have retired, and both the push buffer and the store buffer are empty.

There are two serialized variants. In the single-pipe variant only the primary pipe may receive an instruction. In the paired variant a primary/secondary pair may go out together, provided the superscalar configuration bit is set. Once the debug controller enables it, a special toggle instruction flips the machine between normal and serialized operation. Software must follow that instruction with a no-op. A mode-clear command returns the block to normal dispatch and disables the toggle.

Top module: `npt_dispatch_throttle`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the block is in normal mode with the toggle disabled and no stall pending, so the grants equal the issue-valids in the first cycle after reset.
- R2: In normal mode, gnt_p equals iss_vld_p and gnt_s equals iss_vld_s in the same cycle, whatever the quiescence inputs are, and a grant never causes a stall.
- R3: In single-pipe serialized mode gnt_s is always 0, and gnt_p equals iss_vld_p while no stall is pending.
- R4: In paired serialized mode gnt_s is 1 only when iss_vld_p, iss_vld_s and cfg_superscalar are all 1. With cfg_superscalar at 0, or when the secondary is valid alone, only the primary can be granted.
- R5: After any grant in a serialized mode, both grants are 0 from the next cycle. They stay 0 up to and including the first cycle in which all four quiescence inputs are 1. Grants resume in the cycle after that.
- R6: While a stall is pending, any one quiescence input at 0 (instruction completion, memory idle, push buffer empty, store buffer empty) keeps both grants at 0.
- R7: With the toggle enabled, a granted primary instruction that is flagged by iss_tog_p flips between normal and serialized mode from the next cycle. With the toggle disabled, the flag has no effect. A toggle granted in serialized mode still triggers the quiescence stall.
- R8: A toggle into serialized mode selects the single-pipe variant, unless the paired variant was last selected by dbg_set_dual. That selection persists across toggles.
- R9: A one-cycle pulse on dbg_mode_clr forces normal mode, cancels any pending stall and disables the toggle, from the next cycle on.
- R10: Command priority in one cycle: dbg_mode_clr overrides dbg_set_single, which overrides dbg_set_dual, which overrides a toggle flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_mode_clr | input | 1 | Pulse: return to normal mode and disable the toggle |
| dbg_set_single | input | 1 | Pulse: enter single-pipe serialized mode |
| dbg_set_dual | input | 1 | Pulse: enter paired serialized mode |
| dbg_set_tog_en | input | 1 | Pulse: enable the toggle instruction |
| cfg_superscalar | input | 1 | Allows paired dispatch in the paired serialized mode |
| iss_vld_p | input | 1 | Primary pipe has an instruction to issue |
| iss_vld_s | input | 1 | Secondary pipe has an instruction to issue |
| iss_tog_p | input | 1 | Primary instruction is the toggle instruction |
| xq_insn_done | input | 1 | All outstanding instructions have completed |
| xq_mem_idle | input | 1 | No memory cycle pending |
| xq_push_empty | input | 1 | Push buffer empty |
| xq_store_empty | input | 1 | Store buffer empty |
| gnt_p | output | 1 | Primary pipe dispatch grant |
| gnt_s | output | 1 | Secondary pipe dispatch grant |

## Verification
The assertions assume that debug commands arrive only while the machine is halted, meaning no issue-valid is high in the same cycle. They also assume that a toggle instruction appears only in the primary slot with an empty secondary slot, so that its no-op follower issues alone. The bench drives each command as a one-cycle pulse with both valids low. It presents the toggle flag only with iss_vld_s at 0 and follows it with an idle or plain cycle. The quiescence inputs are driven freely, including one-at-a-time patterns, since the block does not assume anything about their order.

// File: rtl/npt_pkg.sv
`timescale 1ns/1ps
// Shared types for the dispatch throttle.
package npt_pkg;
    // Throttle state: issue permitted, or waiting for machine quiescence.
    typedef enum logic {
        TH_ALLOW = 1'b0,
        TH_WAIT  = 1'b1
    } th_state_e;

    // Mode flags held for the throttle.
    typedef struct packed {
        logic np_on;   // serialized dispatch active
        logic dual;    // paired variant selected
        logic tog_en;  // toggle instruction honoured
    } th_mode_s;
endpackage

// File: rtl/npt_mode_reg.sv
`timescale 1ns/1ps
// Mode register for the dispatch throttle.
// Holds the serialized-mode flags and the toggle enable.
// Assumes commands are one-cycle pulses issued while the core is halted.
// Priority: clear > single > dual > toggle flip. The toggle-enable set is
// independent of the others but still yields to clear.
module npt_mode_reg
    import npt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mode_clr,
    input  logic     set_single,
    input  logic     set_dual,
    input  logic     set_tog_en,
    input  logic     tog_fire,
    output th_mode_s mode
);
    // Update the mode flags from commands and granted toggle instructions.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_clr) begin
            mode <= '0;
        end else begin
            if (set_single) begin
                mode.np_on <= 1'b1;
                mode.dual  <= 1'b0;
            end else if (set_dual) begin
                mode.np_on <= 1'b1;
                mode.dual  <= 1'b1;
            end else if (tog_fire) begin
                mode.np_on <= ~mode.np_on;
            end
            if (set_tog_en) begin
                mode.tog_en <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/npt_quiesce_fsm.sv
`timescale 1ns/1ps
// Two-state quiescence tracker.
// Enters the wait state after a grant in serialized mode. Leaves it only on a
// cycle in which every quiescence source is high, or on a mode clear.
// Assumes the quiescence sources are level signals from the core.
module npt_quiesce_fsm
    import npt_pkg::*;
#(
    parameter int QSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_clr,
    input  logic            np_on,
    input  logic            any_grant,
    input  logic [QSRC-1:0] quiet_vec,
    output th_state_e       state
);
    th_state_e state_nx;
    logic      all_quiet;

    // Every source must report quiet for resynchronization.
    assign all_quiet = &quiet_vec;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            TH_ALLOW: if (np_on && any_grant && !mode_clr) state_nx = TH_WAIT;
            TH_WAIT:  if (mode_clr || all_quiet)           state_nx = TH_ALLOW;
            default:  state_nx = TH_ALLOW;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TH_ALLOW;
        else        state <= state_nx;
    end

    // R6: a wait state with any source not quiet persists.
    p_wait_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TH_WAIT && !all_quiet && !mode_clr) |=> state == TH_WAIT);
    // R5: a quiet cycle in the wait state releases the stall.
    p_wait_exits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TH_WAIT && all_quiet) |=> state == TH_ALLOW);
endmodule

// File: rtl/npt_grant_mux.sv
`timescale 1ns/1ps
// Combinational grant generation for the primary and secondary pipes.
// Assumes the state and mode inputs are registered elsewhere.
module npt_grant_mux
    import npt_pkg::*;
(
    input  th_state_e state,
    input  th_mode_s  mode,
    input  logic      ss_en,
    input  logic      vld_p,
    input  logic      vld_s,
    output logic      gnt_p,
    output logic      gnt_s
);
    // Pick the grants for the current mode and throttle state.
    always_comb begin
        if (state == TH_WAIT) begin
            gnt_p = 1'b0;
            gnt_s = 1'b0;
        end else if (!mode.np_on) begin
            gnt_p = vld_p;
            gnt_s = vld_s;
        end else begin
            gnt_p = vld_p;
            gnt_s = vld_s && vld_p && mode.dual && ss_en;
        end
    end
endmodule

// File: rtl/npt_dispatch_throttle.sv
`timescale 1ns/1ps
// Dispatch throttle between a two-pipe issue stage and the execution pipes.
// In normal mode grants mirror issue-valids. In serialized mode each dispatch
// is followed by a stall until the machine is quiescent.
// Assumes debug commands arrive only while no issue-valid is high, and that the
// toggle instruction issues alone in the primary slot, followed by a no-op.
module npt_dispatch_throttle
    import npt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dbg_mode_clr,
    input  logic dbg_set_single,
    input  logic dbg_set_dual,
    input  logic dbg_set_tog_en,
    input  logic cfg_superscalar,
    input  logic iss_vld_p,
    input  logic iss_vld_s,
    input  logic iss_tog_p,
    input  logic xq_insn_done,
    input  logic xq_mem_idle,
    input  logic xq_push_empty,
    input  logic xq_store_empty,
    output logic gnt_p,
    output logic gnt_s
);
    localparam int QSRC = 4;

    th_mode_s        mode;
    th_state_e       state;
    logic            tog_fire;
    logic            any_grant;
    logic [QSRC-1:0] quiet_vec;

    // Gather the quiescence sources.
    assign quiet_vec = {xq_store_empty, xq_push_empty, xq_mem_idle, xq_insn_done};
    // A granted toggle instruction flips the mode only when enabled.
    assign tog_fire  = mode.tog_en && gnt_p && iss_tog_p;
    // Any dispatch this cycle.
    assign any_grant = gnt_p || gnt_s;

    npt_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_clr   (dbg_mode_clr),
        .set_single (dbg_set_single),
        .set_dual   (dbg_set_dual),
        .set_tog_en (dbg_set_tog_en),
        .tog_fire   (tog_fire),
        .mode       (mode)
    );

    npt_quiesce_fsm #(.QSRC(QSRC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_clr  (dbg_mode_clr),
        .np_on     (mode.np_on),
        .any_grant (any_grant),
        .quiet_vec (quiet_vec),
        .state     (state)
    );

    npt_grant_mux u_mux (
        .state (state),
        .mode  (mode),
        .ss_en (cfg_superscalar),
        .vld_p (iss_vld_p),
        .vld_s (iss_vld_s),
        .gnt_p (gnt_p),
        .gnt_s (gnt_s)
    );

    // R5: a serialized dispatch is followed by a cycle with no grant.
    p_stall_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.np_on && any_grant && !dbg_mode_clr) |=> !(gnt_p || gnt_s));
    // R2: normal mode with no stall never drops a request.
    p_norm_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.np_on && state == TH_ALLOW) |-> (gnt_p == iss_vld_p && gnt_s == iss_vld_s));
    // R3: single-pipe serialized mode never grants the secondary.
    p_single_no_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.np_on && !mode.dual) |-> !gnt_s);
    // R4: a secondary grant in serialized mode needs a full enabled pair.
    p_pair_needs_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.np_on && gnt_s) |-> (cfg_superscalar && mode.dual && gnt_p));
    // R7: an enabled granted toggle with no command flips the mode.
    p_toggle_flips_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_fire && !dbg_mode_clr && !dbg_set_single && !dbg_set_dual)
        |=> mode.np_on != $past(mode.np_on));
    // R9: a clear leaves normal mode, no stall, toggle disabled.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode_clr |=> (!mode.np_on && !mode.tog_en && state == TH_ALLOW));
endmodule

// File: tb/npt_dispatch_throttle_bench.sv
`timescale 1ns/1ps
// Directed bench for the dispatch throttle: one task per scenario.
module npt_dispatch_throttle_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclr = 1'b0, s_single = 1'b0, s_dual = 1'b0, s_tog = 1'b0;
    logic ss_en = 1'b0;
    logic vp = 1'b0, vs = 1'b0, tg = 1'b0;
    logic q_done = 1'b0, q_mem = 1'b0, q_push = 1'b0, q_store = 1'b0;
    logic gnt_p, gnt_s;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    npt_dispatch_throttle u_npt_dispatch_throttle (
        .clk(clk), .rst_n(rst_n),
        .dbg_mode_clr(mclr), .dbg_set_single(s_single),
        .dbg_set_dual(s_dual), .dbg_set_tog_en(s_tog),
        .cfg_superscalar(ss_en),
        .iss_vld_p(vp), .iss_vld_s(vs), .iss_tog_p(tg),
        .xq_insn_done(q_done), .xq_mem_idle(q_mem),
        .xq_push_empty(q_push), .xq_store_empty(q_store),
        .gnt_p(gnt_p), .gnt_s(gnt_s)
    );

    // Advance one clock; inputs change at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drv(input logic p, input logic s, input logic t);
        vp = p; vs = s; tg = t;
    endtask

    task automatic quiet(input logic [3:0] q);
        {q_store, q_push, q_mem, q_done} = q;
    endtask

    // Compare grants {gnt_p,gnt_s} a little after inputs settle.
    task automatic expect_g(input logic [1:0] exp, input string tag);
        #1;
        total++;
        if ({gnt_p, gnt_s} !== exp) begin
            bad++;
            $display("FAIL %s: grants act=%b exp=%b", tag, {gnt_p, gnt_s}, exp);
        end
    endtask

    // One-cycle command pulse with both valids low.
    task automatic cmd(input logic c, input logic s, input logic d, input logic t);
        drv(0, 0, 0);
        mclr = c; s_single = s; s_dual = d; s_tog = t;
        tick();
        mclr = 0; s_single = 0; s_dual = 0; s_tog = 0;
    endtask

    task automatic t_reset();
        quiet(4'b0000);
        drv(1, 1, 0);
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        expect_g(2'b11, "R1 after reset");
        tick();
        expect_g(2'b11, "R1 no stall after reset");
    endtask

    task automatic t_normal();
        cmd(1, 0, 0, 0);
        quiet(4'b0000);
        for (int i = 0; i < 4; i++) begin
            drv(i[1], i[0], 0);
            expect_g(i[1:0], "R2 passthrough");
            tick();
        end
        drv(1, 1, 0);
        expect_g(2'b11, "R2 back-to-back");
        tick();
        expect_g(2'b11, "R2 no stall");
        drv(0, 0, 0);
    endtask

    task automatic t_single();
        cmd(1, 0, 0, 0);
        cmd(0, 1, 0, 0);
        quiet(4'b0000);
        drv(1, 1, 0);
        expect_g(2'b10, "R3 primary only");
        tick();
        expect_g(2'b00, "R5 stall after dispatch");
        for (int i = 0; i < 4; i++) begin
            quiet(~(4'b0001 << i));
            tick();
            expect_g(2'b00, "R6 one source busy");
        end
        quiet(4'b1111);
        expect_g(2'b00, "R5 quiet cycle still stalled");
        tick();
        expect_g(2'b10, "R5 resume after quiet");
        tick();
        expect_g(2'b00, "R5 second stall");
        tick();
        expect_g(2'b10, "R5 second resume");
        drv(0, 0, 0);
        tick();
    endtask

    task automatic t_dual();
        cmd(1, 0, 0, 0);
        cmd(0, 0, 1, 0);
        ss_en = 0;
        quiet(4'b0000);
        drv(1, 1, 0);
        expect_g(2'b10, "R4 pair without superscalar");
        tick();
        quiet(4'b1111);
        expect_g(2'b00, "R5 dual stall");
        tick();
        ss_en = 1;
        expect_g(2'b11, "R4 pair granted");
        tick();
        expect_g(2'b00, "R5 stall after pair");
        tick();
        drv(0, 1, 0);
        expect_g(2'b00, "R4 secondary alone");
        tick();
        drv(1, 1, 0);
        expect_g(2'b11, "R4 pair after idle");
        tick();
        drv(0, 0, 0);
        ss_en = 0;
        tick();
    endtask

    task automatic t_toggle();
        cmd(1, 0, 0, 0);
        quiet(4'b1111);
        drv(1, 0, 1);
        expect_g(2'b10, "R7 disabled toggle granted");
        tick();
        drv(1, 1, 0);
        expect_g(2'b11, "R7 disabled toggle no effect");
        tick();
        expect_g(2'b11, "R7 still normal");
        cmd(0, 0, 0, 1);
        drv(1, 0, 1);
        expect_g(2'b10, "R7 toggle in");
        tick();
        drv(1, 1, 0);
        expect_g(2'b10, "R8 toggled mode is single");
        tick();
        drv(0, 0, 0);
        expect_g(2'b00, "R5 stall after toggled dispatch");
        tick();
        drv(1, 0, 1);
        expect_g(2'b10, "R7 toggle out");
        tick();
        drv(1, 1, 0);
        expect_g(2'b00, "R7 toggle out still stalls");
        tick();
        expect_g(2'b11, "R7 normal after toggle out");
        tick();
        expect_g(2'b11, "R7 normal no stall");
        ss_en = 1;
        cmd(0, 0, 1, 0);
        drv(1, 0, 1);
        expect_g(2'b10, "R7 toggle out of dual");
        tick();
        drv(0, 0, 0);
        expect_g(2'b00, "R5 stall after toggle");
        tick();
        drv(1, 0, 1);
        expect_g(2'b10, "R7 toggle into dual");
        tick();
        drv(1, 1, 0);
        expect_g(2'b11, "R8 dual kept across toggles");
        tick();
        drv(0, 0, 0);
        ss_en = 0;
        tick();
    endtask

    task automatic t_clear();
        cmd(1, 0, 0, 0);
        cmd(0, 0, 0, 1);
        cmd(0, 1, 0, 0);
        quiet(4'b0000);
        drv(1, 1, 0);
        expect_g(2'b10, "R3 single before clear");
        tick();
        expect_g(2'b00, "R5 stalled before clear");
        cmd(1, 0, 0, 0);
        drv(1, 1, 0);
        expect_g(2'b11, "R9 clear cancels stall");
        tick();
        drv(1, 0, 1);
        expect_g(2'b10, "R9 toggle after clear");
        tick();
        drv(1, 1, 0);
        expect_g(2'b11, "R9 toggle disabled by clear");
        tick();
        cmd(1, 1, 0, 0);
        drv(1, 1, 0);
        expect_g(2'b11, "R10 clear beats set");
        tick();
        cmd(0, 1, 1, 0);
        ss_en = 1;
        drv(1, 1, 0);
        expect_g(2'b10, "R10 single beats dual");
        tick();
        expect_g(2'b00, "R5 stall before reset");
        rst_n = 0;
        tick();
        rst_n = 1;
        expect_g(2'b11, "R1 reset clears mode and stall");
        ss_en = 0;
        drv(0, 0, 0);
        tick();
    endtask

    initial begin
        t_reset();
        t_normal();
        t_single();
        t_dual();
        t_toggle();
        t_clear();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule